// File: doc/BRIEF.md
# Single-Error-Correct / Double-Error-Detect Codec for a 16-bit Memory Word

This block protects a 16-bit memory word with six check bits, so each stored word is 22 bits wide. On the write side a combinational encoder computes the check bits from the data. A write-path fault input deliberately stores a word that every later read reports as uncorrectable. On the read side a registered checker takes the 22 stored bits and forms a 6-bit syndrome. It sorts the result into clean, single error or double error, and returns the data with any single data-bit error repaired.

Each data bit has a fixed syndrome code, and each check bit owns one syndrome position. Every single-bit error therefore gives an odd-weight syndrome, and any two-bit error gives a non-zero even-weight syndrome. Two of the parity checks use odd parity so that an all-zero word, as read from an absent array board, is never taken as clean. The syndrome is brought out unchanged so that a fault logger can record which bit or chip failed.

Top module: `secded16_codec`

## Requirements
- R1: The data bit codes are the 6-bit syndrome values, in octal: D0=07, D1=13, D2=23, D3=43, D4=15, D5=25, D6=51, D7=61, D8=16, D9=46, D10=32, D11=62, D12=34, D13=54, D14=64, D15=70. Check bit Ck (check-vector bit k) owns syndrome bit 5-k, so C0=40, C1=20, C2=10, C3=04, C4=02, C5=01. The check-bit output `wr_check[k]` is the parity of the data bits whose code has syndrome bit 5-k set.
- R2: C2 and C4 use odd parity and the other four use even parity. Data 0x0000 and data 0xFFFF both encode to check 6'b010100. An all-zero 22-bit word read back gives syndrome octal 12 and the double-error flag.
- R3: When `wr_force_dbl` is high, the encoder complements C3 and C5 (check bits 3 and 5). Reading such a word back unaltered gives syndrome octal 05 and the double-error flag.
- R4: A stored word that matches its encoding reads back with syndrome zero, no flags, and the data unchanged.
- R5: A single flipped data bit gives that bit's code as the syndrome and raises the single-error flag, and the output data has the bit corrected.
- R6: A single flipped check bit gives a one-hot syndrome at bit 5-k and raises the single-error flag, and the data is returned unchanged.
- R7: Any two flipped bits among the 22 raise the double-error flag only, and the data is returned exactly as read, without correction.
- R8: The outputs load on the clock edge where `rd_valid` is high, and `rsp_valid` is high for the following cycle. Otherwise `rsp_valid` is low and the data, flag and syndrome outputs hold their values.
- R9: While `rst_n` is low, every response output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | 16 | Data to encode |
| wr_force_dbl | input | 1 | Write-path parity fault: store an uncorrectable pattern |
| wr_check | output | 6 | Check bits C0..C5 for `wr_data` (bit k = Ck) |
| rd_valid | input | 1 | Read strobe: check the stored word this cycle |
| rd_data | input | 16 | Stored data bits |
| rd_check | input | 6 | Stored check bits (bit k = Ck) |
| rsp_valid | output | 1 | Response valid, one cycle after `rd_valid` |
| rsp_data | output | 16 | Data, corrected for a single data-bit error |
| rsp_single | output | 1 | Single error detected |
| rsp_double | output | 1 | Double error detected |
| rsp_syndrome | output | 6 | Raw syndrome for fault logging |

## Verification
Clean words (all-zero, all-one and mixed data) confirm that the encoder and checker agree and that the mixed parity senses come out right. Every one of the 22 single-bit flips is applied over several data words, which checks each code's uniqueness, the correction of data bits and the pass-through of check-bit errors. All 231 two-bit pairs on one word check that no pair is mistaken for a single error or wrongly corrected. Directed cases cover the all-zero board read, the forced double write and the holding of the outputs between strobes.

// File: rtl/secded16_codec.sv
module secded16_codec (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] wr_data,
  input  logic        wr_force_dbl,
  output logic [5:0]  wr_check,
  input  logic        rd_valid,
  input  logic [15:0] rd_data,
  input  logic [5:0]  rd_check,
  output logic        rsp_valid,
  output logic [15:0] rsp_data,
  output logic        rsp_single,
  output logic        rsp_double,
  output logic [5:0]  rsp_syndrome
);
  localparam int DW = 16;
  localparam int CW = 6;
  localparam logic [CW-1:0] ODD_SENSE  = 6'b001010;
  localparam logic [CW-1:0] FORCE_MASK = 6'b101000;
  localparam logic [CW-1:0] DCODE [DW] = '{
    6'o07, 6'o13, 6'o23, 6'o43, 6'o15, 6'o25, 6'o51, 6'o61,
    6'o16, 6'o46, 6'o32, 6'o62, 6'o34, 6'o54, 6'o64, 6'o70};

  function automatic logic [CW-1:0] fold(input logic [DW-1:0] d);
    logic [CW-1:0] p;
    p = '0;
    for (int i = 0; i < DW; i++)
      if (d[i]) p = p ^ DCODE[i];
    return p;
  endfunction

  function automatic logic [CW-1:0] rev(input logic [CW-1:0] c);
    logic [CW-1:0] r;
    for (int i = 0; i < CW; i++) r[i] = c[CW-1-i];
    return r;
  endfunction

  logic [CW-1:0] syn;
  logic          is_single, is_double;
  logic [DW-1:0] fix;

  assign wr_check  = rev(fold(wr_data) ^ ODD_SENSE) ^ (wr_force_dbl ? FORCE_MASK : '0);
  assign syn       = fold(rd_data) ^ ODD_SENSE ^ rev(rd_check);
  assign is_single = (syn != '0) &&  (^syn);
  assign is_double = (syn != '0) && !(^syn);

  for (genvar i = 0; i < DW; i++) begin : g_fix
    assign fix[i] = is_single && (syn == DCODE[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rsp_single   <= 1'b0;
      rsp_double   <= 1'b0;
      rsp_syndrome <= '0;
    end else begin
      rsp_valid <= rd_valid;
      if (rd_valid) begin
        rsp_data     <= is_double ? rd_data : (rd_data ^ fix);
        rsp_single   <= is_single;
        rsp_double   <= is_double;
        rsp_syndrome <= syn;
      end
    end
  end

  p_strobe_to_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rsp_valid);

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rsp_valid && $stable(rsp_data) && $stable(rsp_syndrome));

  p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_single && rsp_double));

  p_roundtrip_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !wr_force_dbl && rd_data == wr_data && rd_check == wr_check
    |=> rsp_syndrome == '0 && !rsp_single && !rsp_double && rsp_data == $past(rd_data));

  p_forced_double_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && wr_force_dbl && rd_data == wr_data && rd_check == wr_check
    |=> rsp_double && rsp_syndrome == 6'o05);
endmodule

// File: tb/test_secded16_codec.sv
module test_secded16_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wr_force_dbl = 1'b0;
  logic [5:0]  wr_check;
  logic        rd_valid = 1'b0;
  logic [15:0] rd_data = '0;
  logic [5:0]  rd_check = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        rsp_single, rsp_double;
  logic [5:0]  rsp_syndrome;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  secded16_codec i_secded16_codec (.*);

  localparam logic [5:0] CODE [22] = '{
    6'o07, 6'o13, 6'o23, 6'o43, 6'o15, 6'o25, 6'o51, 6'o61,
    6'o16, 6'o46, 6'o32, 6'o62, 6'o34, 6'o54, 6'o64, 6'o70,
    6'o40, 6'o20, 6'o10, 6'o04, 6'o02, 6'o01};

  // {data, 22-bit flip mask (bit 16+k = Ck), class 0 clean / 1 single / 2 double}
  localparam int NV = 10;
  localparam logic [39:0] VEC [NV] = '{
    {16'h0000, 22'h000000, 2'd0},
    {16'hFFFF, 22'h000000, 2'd0},
    {16'hA5C3, 22'h000001, 2'd1},
    {16'h1234, 22'h008000, 2'd1},
    {16'h1234, 22'h010000, 2'd1},
    {16'h8001, 22'h200000, 2'd1},
    {16'h5A5A, 22'h000003, 2'd2},
    {16'h5A5A, 22'h020008, 2'd2},
    {16'hBEEF, 22'h210000, 2'd2},
    {16'h0F0F, 22'h00C000, 2'd2}};

  function automatic logic [5:0] model_check(input logic [15:0] d);
    logic [5:0] c;
    for (int k = 0; k < 6; k++) begin
      c[k] = (k == 2 || k == 4);
      for (int i = 0; i < 16; i++)
        if (d[i] && CODE[i][5-k]) c[k] = ~c[k];
    end
    return c;
  endfunction

  function automatic logic [5:0] model_syn(input logic [21:0] flip);
    logic [5:0] s = '0;
    for (int i = 0; i < 22; i++) if (flip[i]) s = s ^ CODE[i];
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [15:0] d, input logic [5:0] c);
    @(negedge clk);
    rd_valid = 1'b1; rd_data = d; rd_check = c;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic run_case(input logic [15:0] d, input logic [21:0] flip, input int cls, input string req);
    logic [21:0] w;
    logic [15:0] exp_d;
    w = {model_check(d), d} ^ flip;
    exp_d = (cls == 2) ? w[15:0] : d;
    do_read(w[15:0], w[21:16]);
    chk(rsp_valid, req, rsp_valid, 1);
    chk(rsp_syndrome == model_syn(flip), req, rsp_syndrome, model_syn(flip));
    chk(rsp_single == (cls == 1) && rsp_double == (cls == 2), req,
        {rsp_double, rsp_single}, {cls == 2, cls == 1});
    chk(rsp_data == exp_d, req, rsp_data, exp_d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!rsp_valid && rsp_data == 0 && !rsp_single && !rsp_double && rsp_syndrome == 0,
        "R9", {rsp_valid, rsp_single, rsp_double, rsp_syndrome}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2 encoder directed values
    wr_data = 16'h0000; #1;
    chk(wr_check == 6'b010100, "R2", wr_check, 6'b010100);
    wr_data = 16'hFFFF; #1;
    chk(wr_check == 6'b010100, "R2", wr_check, 6'b010100);
    for (int i = 0; i < 16; i++) begin
      wr_data = 16'h1 << i; #1;
      chk(wr_check == model_check(wr_data), "R1", wr_check, model_check(wr_data));
    end

    // vector table: R4 clean, R5/R6 single, R7 double
    for (int v = 0; v < NV; v++)
      run_case(VEC[v][39:24], VEC[v][23:2], int'(VEC[v][1:0]), "R4/R5/R6/R7 table");

    // every single-bit position over three words
    for (int w = 0; w < 3; w++)
      for (int b = 0; b < 22; b++)
        run_case(w == 0 ? 16'h0000 : (w == 1 ? 16'hC3A5 : 16'hFFFF), 22'h1 << b, 1,
                 b < 16 ? "R5 data single" : "R6 check single");

    // all double-bit pairs on one word
    for (int a = 0; a < 22; a++)
      for (int b = a + 1; b < 22; b++)
        run_case(16'h6C3A, (22'h1 << a) | (22'h1 << b), 2, "R7 pair");

    // R2 absent board: all-zero 22 bits
    do_read(16'h0000, 6'b000000);
    chk(rsp_double && !rsp_single && rsp_syndrome == 6'o12, "R2 missing board",
        {rsp_double, rsp_single, rsp_syndrome}, {2'b10, 6'o12});

    // R3 forced double write
    @(negedge clk);
    wr_data = 16'h3C96; wr_force_dbl = 1'b1; #1;
    chk(wr_check == (model_check(16'h3C96) ^ 6'b101000), "R3 encode", wr_check,
        model_check(16'h3C96) ^ 6'b101000);
    do_read(16'h3C96, wr_check);
    wr_force_dbl = 1'b0;
    chk(rsp_double && !rsp_single && rsp_syndrome == 6'o05, "R3 read",
        {rsp_double, rsp_single, rsp_syndrome}, {2'b10, 6'o05});

    // R8 hold while idle
    run_case(16'h0001, 22'h000002, 1, "R8 setup");
    @(negedge clk);
    rd_data = 16'hFFFF; rd_check = 6'b000000;
    @(negedge clk);
    chk(!rsp_valid && rsp_data == 16'h0001 && rsp_syndrome == 6'o13 && rsp_single,
        "R8 hold", {rsp_valid, rsp_data, rsp_syndrome}, {1'b0, 16'h0001, 6'o13});

    // R9 reset clears after activity
    rst_n = 1'b0;
    @(negedge clk);
    chk(!rsp_valid && rsp_data == 0 && !rsp_single && !rsp_double && rsp_syndrome == 0,
        "R9 reset", {rsp_data, rsp_syndrome}, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule